// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block adds or subtracts two 32-bit operands as packed lanes, lane by lane. A format select picks one of four lane layouts. The first is two unsigned halfwords, with optional clamping. The second is four unsigned bytes and the third is two signed halfwords; both halve their result. The fourth is one signed word, also halved. A direction bit chooses add or subtract. A single mode bit has a different meaning per format: it enables clamping in the unsigned-halfword format and round-to-nearest in the three halving formats.

The unit captures its result in a register on the clock edge that samples `in_valid`. It raises `out_valid` for the following cycle. A sticky overflow flag records every clamp event and stays set until a synchronous clear arrives. A surrounding pipeline drives one operation per valid cycle and reads the flag whenever it needs to.

Top module: `simd_addsub`

## Requirements
- R1: `lane_fmt` encodes 0 = unsigned halfword, 1 = unsigned byte halving, 2 = signed halfword halving, 3 = signed word halving. Lane k reads operand bits [k*W +: W] and writes the result at the same position, where W is the lane width.
- R2: In format 0 with `mode_bit` = 0, each halfword lane returns the low 16 bits of the sum (`sub_sel` = 0) or of the difference (`sub_sel` = 1).
- R3: In format 0 with `mode_bit` = 1 and `sub_sel` = 0, a lane whose sum exceeds 0xFFFF returns 0xFFFF and sets the overflow flag.
- R4: In format 0 with `mode_bit` = 1 and `sub_sel` = 1, a lane whose first operand is smaller than its second returns 0 and sets the overflow flag.
- R5: In format 1, each byte lane returns bits [8:1] of the zero-extended sum or difference, with the borrow kept.
- R6: In format 2, each halfword lane returns bits [16:1] of the sign-extended sum or difference.
- R7: In format 3, the word lane is formed in a 33-bit or wider signed intermediate, so no carry is lost, and bits [32:1] are returned.
- R8: In the halving formats, `mode_bit` = 1 adds 1 to the widened intermediate before the halving shift.
- R9: The overflow flag is sticky. A clamp event in a valid cycle sets it, and a set takes priority over a clear in the same cycle.
- R10: `clr_ovf` clears the flag on the next edge. Formats 1 to 3, and format 0 with `mode_bit` = 0, never set it.
- R11: `result` and `out_valid` appear one cycle after `in_valid`. While `in_valid` is low, `result` holds its value and `out_valid` is 0.
- R12: After synchronous reset, `result`, `out_valid` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 32 | First operand (minuend) |
| opnd_b | input | 32 | Second operand (subtrahend) |
| lane_fmt | input | 2 | Lane format select |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| mode_bit | input | 1 | Clamp enable (format 0) or round enable (formats 1 to 3) |
| clr_ovf | input | 1 | Synchronous clear of the overflow flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered packed result |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Assertions watch four things every cycle: the one-cycle valid latency, result hold while idle, the flag's stickiness and clear, and that non-clamping operations cannot raise the flag. A per-lane assertion also ties every clamp event to a saturated lane value. The lane arithmetic itself can only be shown by the bench's scenarios, which compare against an independent model. That arithmetic covers the carry and borrow edges in each format, the effect of rounding, sign handling at the most negative values, and the wide intermediate in the word format.

// File: rtl/simd_addsub_pkg.sv
// Package: shared lane-format encoding for the packed add/subtract unit.
// Assumes a 2-bit format select driven by the surrounding pipeline.
package simd_addsub_pkg;
    typedef enum logic [1:0] {
        FMT_UHALF_SAT = 2'd0,
        FMT_UBYTE_HLV = 2'd1,
        FMT_SHALF_HLV = 2'd2,
        FMT_SWORD_HLV = 2'd3
    } lane_fmt_e;
endpackage

// File: rtl/simd_sat_lane.sv
// Module: one unsigned lane with modular or clamping add/subtract.
// Assumes: clamp_en gates saturation; ovf reports a clamp event only.
module simd_sat_lane #(
    parameter int LW = 16
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          sub,
    input  logic          clamp_en,
    output logic [LW-1:0] y,
    output logic          ovf
);
    logic [LW:0] wide;
    logic        edge_hit;

    // Widened sum/difference; the top bit is carry-out or borrow.
    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b};
        else     wide = {1'b0, a} + {1'b0, b};
        edge_hit = wide[LW];
    end

    // Clamp to the range limit when enabled, otherwise wrap.
    always_comb begin
        ovf = edge_hit && clamp_en;
        if (ovf) y = sub ? '0 : '1;
        else     y = wide[LW-1:0];
    end
endmodule

// File: rtl/simd_half_lane.sv
// Module: one lane that forms a widened sum/difference, optionally
// adds one for rounding, and returns it halved.
// Assumes: SIGNED selects sign- or zero-extension of both operands.
module simd_half_lane #(
    parameter int LW     = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          sub,
    input  logic          rnd,
    output logic [LW-1:0] y
);
    localparam int EW = LW + 2;
    logic [EW-1:0] ea, eb, acc;

    generate
        if (SIGNED) begin : g_sext
            // Sign-extend operands into the wide intermediate.
            always_comb begin
                ea = {{2{a[LW-1]}}, a};
                eb = {{2{b[LW-1]}}, b};
            end
        end else begin : g_zext
            // Zero-extend operands into the wide intermediate.
            always_comb begin
                ea = {2'b00, a};
                eb = {2'b00, b};
            end
        end
    endgenerate

    // Wide add/sub plus round bit, then drop the lowest bit.
    always_comb begin
        acc = (sub ? (ea - eb) : (ea + eb)) + {{(EW-1){1'b0}}, rnd};
        y   = acc[LW:1];
    end
endmodule

// File: rtl/simd_addsub.sv
// Module: packed lane add/subtract unit with registered result and a
// sticky overflow flag. Assumes one operation per in_valid cycle.
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        lane_fmt,
    input  logic              sub_sel,
    input  logic              mode_bit,
    input  logic              clr_ovf,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf_flag
);
    localparam int HW  = 16;
    localparam int BW  = 8;
    localparam int NH  = DATA_W / HW;
    localparam int NB  = DATA_W / BW;

    logic [DATA_W-1:0] uh_y, ub_y, sh_y, sw_y, next_y;
    logic [NH-1:0]     uh_ovf;
    logic              clamp_on, ovf_set;
    lane_fmt_e         fmt;

    assign fmt      = lane_fmt_e'(lane_fmt);
    assign clamp_on = mode_bit && (fmt == FMT_UHALF_SAT);

    genvar k;
    generate
        for (k = 0; k < NH; k++) begin : g_uh
            simd_sat_lane #(.LW(HW)) u_lane (
                .a(opnd_a[k*HW +: HW]), .b(opnd_b[k*HW +: HW]),
                .sub(sub_sel), .clamp_en(clamp_on),
                .y(uh_y[k*HW +: HW]), .ovf(uh_ovf[k]));
        end
        for (k = 0; k < NB; k++) begin : g_ub
            simd_half_lane #(.LW(BW), .SIGNED(1'b0)) u_lane (
                .a(opnd_a[k*BW +: BW]), .b(opnd_b[k*BW +: BW]),
                .sub(sub_sel), .rnd(mode_bit), .y(ub_y[k*BW +: BW]));
        end
        for (k = 0; k < NH; k++) begin : g_sh
            simd_half_lane #(.LW(HW), .SIGNED(1'b1)) u_lane (
                .a(opnd_a[k*HW +: HW]), .b(opnd_b[k*HW +: HW]),
                .sub(sub_sel), .rnd(mode_bit), .y(sh_y[k*HW +: HW]));
        end
    endgenerate

    simd_half_lane #(.LW(DATA_W), .SIGNED(1'b1)) u_word (
        .a(opnd_a), .b(opnd_b), .sub(sub_sel), .rnd(mode_bit), .y(sw_y));

    // Pick the lane-array output named by the format select.
    always_comb begin
        unique case (fmt)
            FMT_UHALF_SAT: next_y = uh_y;
            FMT_UBYTE_HLV: next_y = ub_y;
            FMT_SHALF_HLV: next_y = sh_y;
            default:       next_y = sw_y;
        endcase
        ovf_set = in_valid && (|uh_ovf);
    end

    // Capture the result on a valid cycle and flag its presence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_y;
        end
    end

    // Sticky overflow: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (clr_ovf) ovf_flag <= 1'b0;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !(in_valid && clamp_on)) |=> !ovf_flag); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !(in_valid && clamp_on)) |=> !ovf_flag); // R10

    generate
        for (k = 0; k < NH; k++) begin : g_chk
            AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && uh_ovf[k]) |=>
                ((result[k*HW +: HW] == '1) || (result[k*HW +: HW] == '0))); // R3
        end
    endgenerate
endmodule

// File: tb/simd_addsub_tb.sv
module simd_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [1:0]  lane_fmt = '0;
    logic        sub_sel = 1'b0, mode_bit = 1'b0, clr_ovf = 1'b0;
    logic        out_valid, ovf_flag;
    logic [31:0] result;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic exp_flag = 1'b0;
    logic [31:0] last_res = '0;

    always #10 clk = ~clk;

    simd_addsub u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .lane_fmt(lane_fmt),
        .sub_sel(sub_sel), .mode_bit(mode_bit), .clr_ovf(clr_ovf),
        .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Reference model: {overflow, result} from the requirements.
    function automatic logic [32:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] f, input logic s, input logic m);
        logic [31:0] r = '0;
        logic ov = 1'b0;
        longint x, pa, pb;
        case (f)
            2'd0: for (int k = 0; k < 2; k++) begin
                pa = longint'(a[16*k +: 16]); pb = longint'(b[16*k +: 16]);
                x = s ? pa - pb : pa + pb;
                if (m && x > 65535)  begin r[16*k +: 16] = 16'hFFFF; ov = 1'b1; end
                else if (m && x < 0) begin r[16*k +: 16] = 16'h0000; ov = 1'b1; end
                else r[16*k +: 16] = 16'(x);
            end
            2'd1: for (int k = 0; k < 4; k++) begin
                pa = longint'(a[8*k +: 8]); pb = longint'(b[8*k +: 8]);
                x = (s ? pa - pb : pa + pb) + longint'(m);
                r[8*k +: 8] = 8'(x >>> 1);
            end
            2'd2: for (int k = 0; k < 2; k++) begin
                pa = longint'($signed(a[16*k +: 16])); pb = longint'($signed(b[16*k +: 16]));
                x = (s ? pa - pb : pa + pb) + longint'(m);
                r[16*k +: 16] = 16'(x >>> 1);
            end
            default: begin
                pa = longint'($signed(a)); pb = longint'($signed(b));
                x = (s ? pa - pb : pa + pb) + longint'(m);
                r = 32'(x >>> 1);
            end
        endcase
        return {ov, r};
    endfunction

    function automatic string fmt_tag(input logic [1:0] f, input logic s, input logic m);
        case (f)
            2'd0: return m ? (s ? "R4 clamp sub" : "R3 clamp add") : "R2 wrap";
            2'd1: return m ? "R8 R5 byte round" : "R5 byte";
            2'd2: return m ? "R8 R6 half round" : "R6 half";
            default: return m ? "R8 R7 word round" : "R7 word";
        endcase
    endfunction

    // One valid operation, checked one cycle later (R1 lane placement via model).
    task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] f,
                      input logic s, input logic m, input logic clr);
        logic [32:0] e;
        e = ref_op(a, b, f, s, m);
        opnd_a = a; opnd_b = b; lane_fmt = f; sub_sel = s; mode_bit = m;
        clr_ovf = clr; in_valid = 1'b1;
        @(negedge clk);
        if (e[32]) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        check({"R1 ", fmt_tag(f, s, m)}, result, e[31:0]);
        check("R11 out_valid", {31'b0, out_valid}, 32'd1);
        check("R9 R10 flag", {31'b0, ovf_flag}, {31'b0, exp_flag});
        last_res = e[31:0];
        in_valid = 1'b0; clr_ovf = 1'b0;
    endtask

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check("R12 reset result", result, 32'h0);
        check("R12 reset valid", {31'b0, out_valid}, 32'd0);
        check("R12 reset flag", {31'b0, ovf_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        op(32'h8000_FFFF, 32'h8000_0001, 2'd0, 1'b0, 1'b0, 1'b0); // R2 wrap both lanes
        op(32'h0001_0005, 32'h0002_0003, 2'd0, 1'b1, 1'b0, 1'b0); // R2 sub wrap
        op(32'h0000_0003, 32'h0000_0007, 2'd1, 1'b0, 1'b1, 1'b0); // R10 rounding ops don't set
        op(32'h1234_FFFF, 32'h0001_0001, 2'd0, 1'b0, 1'b1, 1'b0); // R3 upper lane plain, lower clamps
        op(32'h0, 32'h0, 2'd3, 1'b0, 1'b0, 1'b1);                  // R10 clear
        op(32'h0001_0009, 32'h0002_0004, 2'd0, 1'b1, 1'b1, 1'b1);  // R4 R9 set beats clear
        op(32'h0, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0);                  // R9 stays set
        op(32'h0, 32'h0, 2'd1, 1'b0, 1'b0, 1'b1);                  // R10 clear
        op(32'hFF00_01FF, 32'hFF01_0000, 2'd1, 1'b0, 1'b1, 1'b0);  // R5 R8 byte edges
        op(32'h0000_0000, 32'h0101_0101, 2'd1, 1'b1, 1'b0, 1'b0);  // R5 borrow kept
        op(32'h7FFF_8000, 32'h7FFF_8000, 2'd2, 1'b0, 1'b0, 1'b0);  // R6 extremes
        op(32'h8000_7FFF, 32'h0001_8000, 2'd2, 1'b1, 1'b1, 1'b0);  // R6 R8 sub round
        op(32'h7FFF_FFFF, 32'h0000_0001, 2'd3, 1'b0, 1'b0, 1'b0);  // R7 carry kept
        op(32'h8000_0000, 32'h0000_0001, 2'd3, 1'b1, 1'b1, 1'b0);  // R7 R8

        // R11 idle: operands change, result holds, no valid
        opnd_a = 32'hDEAD_BEEF; lane_fmt = 2'd0; mode_bit = 1'b1; sub_sel = 1'b1;
        opnd_b = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R11 idle hold", result, last_res);
        check("R11 idle valid", {31'b0, out_valid}, 32'd0);
        check("R10 idle no set", {31'b0, ovf_flag}, {31'b0, exp_flag});

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if (i % 7 == 0) ra[15:0] = 16'hFFFF;
            if (i % 11 == 0) rb[31:16] = 16'h8000;
            op(ra, rb, 2'($urandom % 4), 1'($urandom), 1'($urandom),
               ($urandom % 5) == 0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule